// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer for a successive-approximation analog-to-digital converter inside a microcontroller. A conversion starts in one of two ways. Software can pulse a start request. Alternatively, a continuous-trigger mode starts a conversion on every rising edge of an external trigger clock, after that clock has been brought into the block's clock domain. Each conversion has three parts: it connects the selected analog channel to the sample-and-hold for a fixed window, it runs a bit-by-bit binary search against a comparator input, and it then raises a completion flag.

The block presents a trial code to the external DAC and reads back a single comparator bit. That bit is 1 when the held analog voltage is at or above the trial code. The block writes each decided bit into the result as soon as that bit is known. The result is split into a 2-bit high part and an 8-bit low part. The block clears its busy flag and sets the interrupt flag on the same clock edge. The interrupt flag then stays set until software clears it.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy, the interrupt flag, the interrupt output and the whole result read 0.
- R2: With continuous trigger off, a software start pulse sets busy on the next edge. On that same edge the channel select is latched onto `chan_o`, and `sample_o` stays high for exactly the first 16 cycles of busy.
- R3: Busy stays high for exactly 38 cycles. It falls on the same edge on which the interrupt flag rises.
- R4: The search decides bits from MSB to LSB, with `cmp_i` = 1 meaning the input is at or above `dac_code_o`. The final result equals the input code: `res_hi_o` holds bits 9:8 and `res_lo_o` holds bits 7:0.
- R5: Each bit is written into the result as it is decided. The MSB is decided 19 edges after the start edge, and at that point the lower bits still read 0.
- R6: With continuous trigger on, a rising edge of `trig_i` sets busy on the third clock edge after the change (two synchronizer flops, then edge detection). Software start pulses are ignored in this mode.
- R7: With continuous trigger off, edges on `trig_i` never start a conversion.
- R8: A start request of either kind that arrives while busy is 1 is ignored: the running conversion keeps its timing and its result, and no conversion follows it.
- R9: The interrupt flag holds until a pulse on `irq_clr_i`. `irq_o` is high only while both the flag and `irq_en_i` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel_i | input | 3 | Analog channel to convert |
| sw_start_i | input | 1 | Software start pulse |
| cont_en_i | input | 1 | Continuous-trigger mode enable |
| trig_i | input | 1 | Asynchronous trigger clock |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Software clear of the interrupt flag |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the trial code |
| dac_code_o | output | 10 | Trial code to the DAC |
| sample_o | output | 1 | Sample-and-hold connect |
| chan_o | output | 3 | Channel latched at start |
| busy_o | output | 1 | Conversion in progress |
| irq_flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt request |
| res_hi_o | output | 2 | Result bits 9:8 |
| res_lo_o | output | 8 | Result bits 7:0 |

## Verification
All timing is counted from the start edge E0, the first edge after which busy reads 1. The sampling output drops after E16. The MSB shows in the result after E19. Busy falls and the flag rises after E38. For a trigger edge, busy appears after the third edge following the change on `trig_i`. The bench drives inputs and samples outputs on falling edges, so each check lands in the half-cycle after the edge that is due to change the output. Every check therefore counts falling edges from the start edge, rather than waiting for a level.

// File: rtl/sar_pkg.sv
package sar_pkg;
    parameter int RES_W      = 10;
    parameter int HI_W       = 2;
    parameter int CH_W       = 3;
    parameter int SAMPLE_CYC = 16;
    parameter int SYNC_STG   = 2;
    // setup + two cycles per bit + finish
    localparam int TOTAL_CYC = SAMPLE_CYC + 2 * RES_W + 2;
    localparam int CNT_W     = $clog2(TOTAL_CYC);
    localparam int LO_W      = RES_W - HI_W;
    typedef logic [RES_W-1:0] code_t;
endpackage

// File: rtl/sar_trig_detect.sv
module sar_trig_detect #(
    parameter int STAGES = sar_pkg::SYNC_STG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } trig_st_t;

    trig_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], trig_i};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sync[STAGES-1] & ~st_q.prev;

    // R6: one trigger edge gives a single-cycle pulse
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl
    import sar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic busy_o,
    output logic sample_o,
    output logic init_o,
    output logic decide_o,
    output logic done_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } ctl_st_t;

    localparam logic [CNT_W-1:0] SAMP_END = CNT_W'(SAMPLE_CYC);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TOTAL_CYC - 1);

    ctl_st_t          st_d, st_q;
    logic [CNT_W-1:0] rel;

    assign accept_o = start_i & ~st_q.busy;

    always_comb begin
        st_d = st_q;
        if (accept_o) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            if (st_q.cnt == LAST_CNT) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rel      = st_q.cnt - SAMP_END;
    assign busy_o   = st_q.busy;
    assign sample_o = st_q.busy & (st_q.cnt < SAMP_END);
    assign init_o   = st_q.busy & (st_q.cnt == SAMP_END);
    assign decide_o = st_q.busy & (st_q.cnt > SAMP_END) & (st_q.cnt < LAST_CNT) & ~rel[0];
    assign done_o   = st_q.busy & (st_q.cnt == LAST_CNT);

    // R8: a running conversion advances one step per cycle whatever the start input does
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> (busy_o && st_q.cnt == $past(st_q.cnt) + 1'b1));
    // R3: the finish step is the last busy cycle
    p_len_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    // R2: sampling opens the conversion
    p_sample_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> sample_o);
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg
    import sar_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear_i,
    input  logic  init_i,
    input  logic  decide_i,
    input  logic  cmp_i,
    output code_t trial_o,
    output code_t result_o
);
    typedef struct packed {
        code_t trial;
        code_t ptr;
        code_t result;
    } sar_st_t;

    sar_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (init_i) begin
            st_d.ptr   = code_t'(1) << (RES_W - 1);
            st_d.trial = code_t'(1) << (RES_W - 1);
        end else if (decide_i) begin
            st_d.result = cmp_i ? (st_q.result | st_q.ptr) : (st_q.result & ~st_q.ptr);
            st_d.trial  = (cmp_i ? st_q.trial : (st_q.trial & ~st_q.ptr)) | (st_q.ptr >> 1);
            st_d.ptr    = st_q.ptr >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trial_o  = st_q.trial;
    assign result_o = st_q.result;

    // R4: exactly one bit is under test at a time
    p_ptr_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.ptr));
    // R5: the result moves only on a decision or a new start
    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!decide_i && !clear_i) |=> $stable(st_q.result));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_W-1:0]  chan_sel_i,
    input  logic             sw_start_i,
    input  logic             cont_en_i,
    input  logic             trig_i,
    input  logic             irq_en_i,
    input  logic             irq_clr_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] dac_code_o,
    output logic             sample_o,
    output logic [CH_W-1:0]  chan_o,
    output logic             busy_o,
    output logic             irq_flag_o,
    output logic             irq_o,
    output logic [HI_W-1:0]  res_hi_o,
    output logic [LO_W-1:0]  res_lo_o
);
    typedef struct packed {
        logic            flag;
        logic [CH_W-1:0] chan;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    trig_rise, start_req, accept, init, decide, done;
    code_t   result;

    sar_trig_detect #(.STAGES(SYNC_STG)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .rise_o (trig_rise)
    );

    assign start_req = cont_en_i ? trig_rise : sw_start_i;

    sar_step_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_req),
        .accept_o (accept),
        .busy_o   (busy_o),
        .sample_o (sample_o),
        .init_o   (init),
        .decide_o (decide),
        .done_o   (done)
    );

    sar_approx_reg u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .init_i   (init),
        .decide_i (decide),
        .cmp_i    (cmp_i),
        .trial_o  (dac_code_o),
        .result_o (result)
    );

    always_comb begin
        st_d = st_q;
        if (accept)         st_d.chan = chan_sel_i;
        if (done)           st_d.flag = 1'b1;
        else if (irq_clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chan_o     = st_q.chan;
    assign irq_flag_o = st_q.flag;
    assign irq_o      = st_q.flag & irq_en_i;
    assign res_hi_o   = result[RES_W-1 -: HI_W];
    assign res_lo_o   = result[LO_W-1:0];

    // R3: busy falls on the edge that raises the flag
    p_done_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> irq_flag_o);
    // R9: the flag holds until cleared
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag_o && !irq_clr_i) |=> irq_flag_o);
    // R7: with triggering off and no software start, an idle block stays idle
    p_trig_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont_en_i && !sw_start_i && !busy_o) |=> !busy_o);
endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] chan_sel_i = '0;
    logic       sw_start_i = 1'b0, cont_en_i = 1'b0, trig_i = 1'b0;
    logic       irq_en_i = 1'b0, irq_clr_i = 1'b0;
    logic       cmp_i;
    logic [9:0] dac_code_o;
    logic       sample_o, busy_o, irq_flag_o, irq_o;
    logic [2:0] chan_o;
    logic [1:0] res_hi_o;
    logic [7:0] res_lo_o;
    logic [9:0] tgt = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // analog model: input at or above trial code gives 1
    assign cmp_i = (tgt >= dac_code_o);

    sar_seq u_dut (
        .clk(clk), .rst_n(rst_n), .chan_sel_i(chan_sel_i), .sw_start_i(sw_start_i),
        .cont_en_i(cont_en_i), .trig_i(trig_i), .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
        .cmp_i(cmp_i), .dac_code_o(dac_code_o), .sample_o(sample_o), .chan_o(chan_o),
        .busy_o(busy_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o),
        .res_hi_o(res_hi_o), .res_lo_o(res_lo_o)
    );

    function automatic logic [9:0] full_res();
        return {res_hi_o, res_lo_o};
    endfunction

    function automatic logic [9:0] msb_only(input logic [9:0] code);
        return {code[9], 9'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // software conversion; E0 is the edge between the first two falling edges
    task automatic run_sw(input logic [9:0] code, input logic [2:0] ch, input bit poke);
        tgt = code;
        chan_sel_i = ch;
        sw_start_i = 1'b1;
        irq_clr_i = 1'b1;
        @(negedge clk);
        sw_start_i = 1'b0;
        irq_clr_i = 1'b0;
        chk("R2 busy after start", busy_o, 1);
        chk("R2 channel latched", chan_o, ch);
        chk("R2 sampling open", sample_o, 1);
        chan_sel_i = ~ch;
        repeat (15) @(negedge clk);
        chk("R2 sampling at E15", sample_o, 1);
        @(negedge clk);
        chk("R2 sampling closed at E16", sample_o, 0);
        repeat (3) @(negedge clk);
        chk("R5 MSB written first", full_res(), msb_only(code));
        if (poke) begin
            sw_start_i = 1'b1;
            @(negedge clk);
            sw_start_i = 1'b0;
            repeat (17) @(negedge clk);
        end else begin
            repeat (18) @(negedge clk);
        end
        chk("R3 busy at E37", busy_o, 1);
        chk("R3 flag low at E37", irq_flag_o, 0);
        @(negedge clk);
        chk("R3 busy low at E38", busy_o, 0);
        chk("R3 flag set at E38", irq_flag_o, 1);
        chk("R4 result", full_res(), code);
        chk("R4 high part", res_hi_o, code[9:8]);
        chk("R4 channel kept", chan_o, ch);
        if (poke) begin
            repeat (3) @(negedge clk);
            chk("R8 no start after busy", busy_o, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        chk("R1 busy", busy_o, 0);
        chk("R1 flag", irq_flag_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 result", full_res(), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corner codes
        run_sw(10'd0, 3'd0, 0);
        run_sw(10'h3FF, 3'd7, 0);
        run_sw(10'h200, 3'd2, 0);
        run_sw(10'h1FF, 3'd5, 0);
        // R8 software start while busy
        run_sw(10'h2A5, 3'd3, 1);

        // R9 flag and enable
        irq_en_i = 1'b1;
        @(negedge clk);
        chk("R9 irq with enable", irq_o, 1);
        irq_en_i = 1'b0;
        @(negedge clk);
        chk("R9 irq masked", irq_o, 0);
        repeat (5) @(negedge clk);
        chk("R9 flag holds", irq_flag_o, 1);
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
        chk("R9 flag cleared", irq_flag_o, 0);
        irq_en_i = 1'b1;
        @(negedge clk);
        chk("R9 irq after clear", irq_o, 0);
        irq_en_i = 1'b0;

        // R7 trigger ignored in software mode
        repeat (4) @(negedge clk);
        trig_i = 1'b1;
        repeat (5) @(negedge clk);
        chk("R7 trigger ignored", busy_o, 0);
        trig_i = 1'b0;
        repeat (4) @(negedge clk);

        // R6 trigger mode
        cont_en_i = 1'b1;
        tgt = 10'h13C;
        chan_sel_i = 3'd6;
        sw_start_i = 1'b1;
        @(negedge clk);
        sw_start_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 software start ignored", busy_o, 0);
        trig_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 not yet busy", busy_o, 0);
        @(negedge clk);
        chk("R6 busy third edge", busy_o, 1);
        chk("R6 channel", chan_o, 3'd6);
        trig_i = 1'b0;
        repeat (4) @(negedge clk);
        trig_i = 1'b1;
        repeat (33) @(negedge clk);
        chk("R8 busy kept at E37", busy_o, 1);
        @(negedge clk);
        chk("R8 busy ends on time", busy_o, 0);
        chk("R6 trigger result", full_res(), 10'h13C);
        repeat (3) @(negedge clk);
        chk("R8 no pending trigger", busy_o, 0);
        trig_i = 1'b0;
        cont_en_i = 1'b0;
        repeat (4) @(negedge clk);

        // random codes and channels
        for (int i = 0; i < 16; i++) begin
            run_sw(10'($urandom), 3'($urandom), 0);
        end
        finish_run();
    end
endmodule